// File: doc/BRIEF.md
# SRAM Bus Cycle Generator

This block turns single read or write requests aimed at one external memory area into SRAM-style strobes. After it accepts a request, it drives an active-low chip select, a one-cycle bus-start marker, an active-low read strobe and one active-low write enable per byte lane. The read strobe can serve directly as the memory's output enable. Address and write data are held stable on the pins for the whole access.

Every access runs through the same sequence of phases:

- an optional setup cycle, in which chip select and address lead the strobe;
- the strobe window, made of T1, a programmed number of wait cycles and the closing T2;
- an optional hold of zero to three cycles, in which chip select stays asserted after the strobe has gone.

An external ready input can lengthen the strobe window as long as it is held low. When the access is over, a one-cycle done pulse is raised, carrying the captured read data.

The request side uses a valid/ready handshake. A new request is accepted when the block is idle, or in the final cycle of the access in progress. At minimum pitch, chip select therefore stays low with no gap between accesses. Setup, wait and hold are sampled from the configuration inputs when a request is accepted, and are then fixed for that access.

Top module: `sramCycleGen`

## Requirements
- R1: In reset and afterwards when idle, chip select, bus start, read strobe and all write enables are high (inactive), rspDone is low and reqReady is high.
- R2: With zero wait, setup and hold, chip select is low for exactly two cycles. It asserts in the cycle after the request is accepted.
- R3: Bus start is low for exactly one cycle per access, and that cycle is the first cycle in which chip select is low.
- R4: With cfgWait = W and ready high, the strobe is low for W+2 consecutive cycles (W from 0 to 15).
- R5: The ready input is sampled at the clock edge that closes the last programmed wait cycle, or T1 when W = 0. Each such edge with ready low adds one strobe cycle.
- R6: With cfgSetup = 1, chip select is low for exactly one cycle before the strobe starts. With cfgSetup = 0, the strobe starts in the first chip select cycle.
- R7: With cfgHold = H (0 to 3), chip select stays low for exactly H cycles after the strobe ends.
- R8: On a read (reqWrite = 0), memRdN is low during the strobe and every bit of memWeN stays high, whatever reqMask holds. rspRdata returns all DATA_W bits of memRdata, captured at the edge that ends the strobe.
- R9: On a write (reqWrite = 1), memWeN[i] is low during the strobe only where reqMask[i] = 1 (bit i is byte lane i), and memRdN stays high. memWdata equals reqWdata and memDataOe is high.
- R10: reqReady is high in the final cycle of an access and low in its earlier cycles. A request accepted in that final cycle starts its own bus cycle in the next cycle, with chip select held low across the boundary.
- R11: rspDone is a one-cycle pulse in the cycle right after the last chip select cycle of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqMask | input | DATA_W/8 | Byte lanes to write |
| reqWdata | input | DATA_W | Write data |
| cfgWait | input | WAIT_W | Programmed wait cycles |
| cfgSetup | input | 1 | Insert one setup cycle before the strobe |
| cfgHold | input | HOLD_W | Hold cycles after the strobe |
| busReady | input | 1 | External ready, low stretches the strobe |
| memRdata | input | DATA_W | Data from memory |
| memAddr | output | ADDR_W | Address to memory |
| memWdata | output | DATA_W | Data to memory |
| memDataOe | output | 1 | Drive enable for the data pins |
| memCsN | output | 1 | Chip select, active low |
| memBsN | output | 1 | Bus start marker, active low |
| memRdN | output | 1 | Read strobe / output enable, active low |
| memWeN | output | DATA_W/8 | Per-lane write enables, active low |
| rspRdata | output | DATA_W | Captured read data |
| rspDone | output | 1 | Access finished, one-cycle pulse |

## Verification
Counted from the edge that accepts a request, chip select and bus start are due one cycle later. The strobe is due after a further cfgSetup cycles and lasts W+2 cycles plus one per low-ready sample. Chip select then trails by H cycles, and rspDone with the read data is due in the first cycle after chip select rises. The bench drives and samples only at falling clock edges, counting the low cycles of each strobe per access. Ready is lowered exactly on the strobe cycles whose closing edge is a sampling point, so each expected width follows from the configuration alone. For the back-to-back case, the bench steps cycle by cycle through the two-cycle pitch and checks the boundary cycle directly.

// File: rtl/sramCycPkg.sv
package sramCycPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_LAST,
    ST_HOLD
  } cycState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted this cycle
    logic capture;  // closing strobe cycle, sample read data at its edge
    logic finish;   // final cycle of the access
    logic cs;       // chip select active
    logic bs;       // first cycle of the bus cycle
    logic strobe;   // read/write strobe window
  } cycCtrl_t;

endpackage

// File: rtl/sramCycCtrl.sv
module sramCycCtrl
  import sramCycPkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgSetup,
  input  logic [HOLD_W-1:0] cfgHold,
  input  logic              busReady,
  output cycCtrl_t          ctrl
);

  localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  cycState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] waitLim;
  logic [CNT_W-1:0] holdLim;
  logic             bsFlag;
  logic             idle;
  logic             finalCyc;
  logic             accept;

  assign idle     = (state == ST_IDLE);
  assign finalCyc = ((state == ST_LAST) && (holdLim == '0)) ||
                    ((state == ST_HOLD) && (cnt == holdLim));
  assign reqReady = idle || finalCyc;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      waitLim <= '0;
      holdLim <= '0;
      bsFlag  <= 1'b0;
    end else if (accept) begin
      waitLim <= CNT_W'(cfgWait);
      holdLim <= CNT_W'(cfgHold);
      cnt     <= '0;
      bsFlag  <= 1'b1;
      state   <= cfgSetup ? ST_SETUP : ST_STRB;
    end else begin
      bsFlag <= 1'b0;
      case (state)
        ST_SETUP: begin
          state <= ST_STRB;
          cnt   <= '0;
        end
        ST_STRB: begin
          if (cnt < waitLim) begin
            cnt <= cnt + 1'b1;
          end else if (busReady) begin
            state <= ST_LAST;
          end
        end
        ST_LAST: begin
          if (holdLim != '0) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (cnt == holdLim) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.load    = accept;
    ctrl.capture = (state == ST_LAST);
    ctrl.finish  = finalCyc;
    ctrl.cs      = !idle;
    ctrl.bs      = bsFlag;
    ctrl.strobe  = (state == ST_STRB) || (state == ST_LAST);
  end

endmodule

// File: rtl/sramCycData.sv
module sramCycData
  import sramCycPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  cycCtrl_t            ctrl,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memDataOe,
  output logic                memCsN,
  output logic                memBsN,
  output logic                memRdN,
  output logic [DATA_W/8-1:0] memWeN,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                rspDone
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic              writeQ;
  logic [DATA_W-1:0] rdataQ;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
      writeQ <= 1'b0;
    end else if (ctrl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= ctrl.finish;
      if (ctrl.capture && !writeQ) begin
        rdataQ <= memRdata;
      end
    end
  end

  assign memAddr   = addrQ;
  assign memWdata  = wdataQ;
  assign memDataOe = ctrl.cs && writeQ;
  assign memCsN    = !ctrl.cs;
  assign memBsN    = !ctrl.bs;
  assign memRdN    = !(ctrl.strobe && !writeQ);
  assign rspRdata  = rdataQ;
  assign rspDone   = doneQ;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign memWeN[lane] = !(ctrl.strobe && writeQ && maskQ[lane]);
  end

endmodule

// File: rtl/sramCycleGen.sv
module sramCycleGen
  import sramCycPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [WAIT_W-1:0]   cfgWait,
  input  logic                cfgSetup,
  input  logic [HOLD_W-1:0]   cfgHold,
  input  logic                busReady,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memDataOe,
  output logic                memCsN,
  output logic                memBsN,
  output logic                memRdN,
  output logic [DATA_W/8-1:0] memWeN,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                rspDone
);

  cycCtrl_t ctrl;

  sramCycCtrl #(
    .WAIT_W(WAIT_W),
    .HOLD_W(HOLD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .cfgWait  (cfgWait),
    .cfgSetup (cfgSetup),
    .cfgHold  (cfgHold),
    .busReady (busReady),
    .ctrl     (ctrl)
  );

  sramCycData #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqMask   (reqMask),
    .reqWdata  (reqWdata),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memDataOe (memDataOe),
    .memCsN    (memCsN),
    .memBsN    (memBsN),
    .memRdN    (memRdN),
    .memWeN    (memWeN),
    .rspRdata  (rspRdata),
    .rspDone   (rspDone)
  );

endmodule

// File: rtl/sramCycleGen_chk.sv
module sramCycleGen_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             memCsN,
  input logic             memBsN,
  input logic             memRdN,
  input logic [LANES-1:0] memWeN,
  input logic             rspDone
);

  // R3
  bs_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memBsN |=> memBsN);

  // R3
  bs_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memBsN |-> !memCsN);

  // R8
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> (&memWeN));

  // R6
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdN || !(&memWeN)) |-> !memCsN);

  // R10
  accept_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !memBsN);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R11
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspDone) |-> $past(!memCsN));

endmodule

bind sramCycleGen sramCycleGen_chk #(.LANES(DATA_W / 8)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .memCsN   (memCsN),
  .memBsN   (memBsN),
  .memRdN   (memRdN),
  .memWeN   (memWeN),
  .rspDone  (rspDone)
);

// File: tb/sramCycleGen_tb.sv
`timescale 1ns/1ps
module sramCycleGen_tb;

  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic              wr;
    logic [3:0]        mask;
    logic [3:0]        waits;
    logic              setup;
    logic [1:0]        hold;
    logic [1:0]        stretch;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 4'h1, 4'd0,  1'b0, 2'd0, 2'd0, 26'h0000010, 32'h00000000},
    '{1'b0, 4'hF, 4'd3,  1'b1, 2'd2, 2'd0, 26'h1234567, 32'h00000000},
    '{1'b1, 4'h5, 4'd0,  1'b0, 2'd0, 2'd0, 26'h0ABCDE0, 32'hDEADBEEF},
    '{1'b1, 4'hA, 4'd15, 1'b0, 2'd3, 2'd0, 26'h3FFFFFF, 32'h01234567},
    '{1'b0, 4'h0, 4'd2,  1'b0, 2'd0, 2'd2, 26'h2000004, 32'h00000000},
    '{1'b1, 4'hF, 4'd0,  1'b1, 2'd1, 2'd3, 26'h0000100, 32'hCAFEF00D},
    '{1'b0, 4'h8, 4'd15, 1'b1, 2'd3, 2'd1, 26'h155AAAA, 32'h00000000},
    '{1'b1, 4'h3, 4'd1,  1'b0, 2'd0, 2'd0, 26'h0777770, 32'h5A5A5A5A}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LANES-1:0]  reqMask = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [3:0]        cfgWait = '0;
  logic              cfgSetup = 1'b0;
  logic [1:0]        cfgHold = '0;
  logic              busReady = 1'b1;
  logic [DATA_W-1:0] memRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memDataOe;
  logic              memCsN;
  logic              memBsN;
  logic              memRdN;
  logic [LANES-1:0]  memWeN;
  logic [DATA_W-1:0] rspRdata;
  logic              rspDone;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // memory model: read data is a fixed function of the address
  assign memRdata = {6'h2A, memAddr};

  sramCycleGen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqMask(reqMask),
    .reqWdata(reqWdata), .cfgWait(cfgWait), .cfgSetup(cfgSetup),
    .cfgHold(cfgHold), .busReady(busReady), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memDataOe(memDataOe),
    .memCsN(memCsN), .memBsN(memBsN), .memRdN(memRdN), .memWeN(memWeN),
    .rspRdata(rspRdata), .rspDone(rspDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int csCnt = 0, stCnt = 0, lead = 0, tail = 0, bsCnt = 0, doneCnt = 0;
    bit bsFirst = 1'b0, weBad = 1'b0, rdBad = 1'b0, wdBad = 1'b0, gotDone = 1'b0;
    logic [DATA_W-1:0] rdGot = '0;
    logic [LANES-1:0] weExp;
    bit strobe;
    weExp = v.wr ? ~v.mask : {LANES{1'b1}};
    @(negedge clk);
    reqValid = 1'b1; reqWrite = v.wr; reqAddr = v.addr; reqMask = v.mask;
    reqWdata = v.data; cfgWait = v.waits; cfgSetup = v.setup; cfgHold = v.hold;
    busReady = 1'b1;
    check(reqReady == 1'b1, "R1", $sformatf("vec%0d ready when idle", idx), reqReady, 1);
    for (int cyc = 0; cyc < 80 && !gotDone; cyc++) begin
      @(negedge clk);
      if (cyc == 0) reqValid = 1'b0;
      strobe = !memRdN || (memWeN != {LANES{1'b1}});
      if (!memCsN) begin
        csCnt++;
        if (!memBsN && csCnt == 1) bsFirst = 1'b1;
        if (strobe) stCnt++;
        else if (stCnt == 0) lead++;
        else tail++;
      end
      if (!memBsN) bsCnt++;
      if (strobe || (!memCsN && stCnt == 0)) begin
        if (strobe && memWeN != weExp) weBad = 1'b1;
        if (strobe && memRdN != v.wr) rdBad = 1'b1;
      end
      if (!memCsN && v.wr && (memWdata != v.data || !memDataOe)) wdBad = 1'b1;
      if (strobe)
        busReady = !(stCnt >= int'(v.waits) + 1 && stCnt <= int'(v.waits) + int'(v.stretch));
      else
        busReady = 1'b1;
      if (rspDone) begin
        gotDone = 1'b1;
        doneCnt++;
        rdGot = rspRdata;
        check(memCsN == 1'b1, "R11", $sformatf("vec%0d done after cs", idx), memCsN, 1);
      end
    end
    busReady = 1'b1;
    check(csCnt == int'(v.setup) + 2 + int'(v.waits) + int'(v.stretch) + int'(v.hold),
          "R2", $sformatf("vec%0d cs cycles", idx), csCnt,
          int'(v.setup) + 2 + int'(v.waits) + int'(v.stretch) + int'(v.hold));
    // R4 and R5: strobe width
    check(stCnt == 2 + int'(v.waits) + int'(v.stretch), v.stretch != 0 ? "R5" : "R4",
          $sformatf("vec%0d strobe cycles", idx), stCnt, 2 + int'(v.waits) + int'(v.stretch));
    check(lead == int'(v.setup), "R6", $sformatf("vec%0d setup cycles", idx), lead, v.setup);
    check(tail == int'(v.hold), "R7", $sformatf("vec%0d hold cycles", idx), tail, v.hold);
    check(bsCnt == 1 && bsFirst, "R3", $sformatf("vec%0d bus start", idx), bsCnt, 1);
    check(!weBad, v.wr ? "R9" : "R8", $sformatf("vec%0d write enables", idx), weBad, 0);
    check(!rdBad, v.wr ? "R9" : "R8", $sformatf("vec%0d read strobe", idx), rdBad, 0);
    check(doneCnt == 1, "R11", $sformatf("vec%0d done pulse", idx), doneCnt, 1);
    if (v.wr)
      check(!wdBad, "R9", $sformatf("vec%0d write data", idx), wdBad, 0);
    else
      check(rdGot == {6'h2A, v.addr}, "R8", $sformatf("vec%0d read data", idx),
            rdGot, {6'h2A, v.addr});
    @(negedge clk);
    check(rspDone == 1'b0 && memCsN == 1'b1, "R11", $sformatf("vec%0d idle after", idx),
          {rspDone, memCsN}, 2'b01);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memCsN && memBsN && memRdN && (&memWeN) && !rspDone && reqReady,
          "R1", "reset state", {memCsN, memBsN, memRdN, &memWeN, rspDone, reqReady}, 6'b111101);
    rstN = 1'b1;
    @(negedge clk);
    check(memCsN && memRdN && (&memWeN) && reqReady, "R1", "idle after reset",
          {memCsN, memRdN, &memWeN, reqReady}, 4'b1111);

    for (int i = 0; i < NVEC; i++) runVec(VEC[i], i);

    // back-to-back minimum-pitch reads, R10
    @(negedge clk);
    cfgWait = '0; cfgSetup = 1'b0; cfgHold = '0; busReady = 1'b1;
    reqWrite = 1'b0; reqMask = '0; reqAddr = 26'h0111111; reqValid = 1'b1;
    @(negedge clk);  // T1 of first
    check(!memCsN && !memBsN && !reqReady, "R10", "first T1 busy",
          {memCsN, memBsN, reqReady}, 3'b000);
    reqAddr = 26'h0222222;
    @(negedge clk);  // T2 of first, final cycle
    check(reqReady && !memCsN && memBsN, "R10", "ready in final cycle",
          {reqReady, memCsN, memBsN}, 3'b101);
    @(negedge clk);  // T1 of second
    reqValid = 1'b0;
    check(!memCsN && !memBsN && memAddr == 26'h0222222, "R10", "no cs gap",
          {memCsN, memBsN}, 2'b00);
    check(rspDone && rspRdata == {6'h2A, 26'h0111111}, "R11", "first done in pitch",
          rspRdata, {6'h2A, 26'h0111111});
    @(negedge clk);  // T2 of second
    check(!memCsN && !rspDone, "R10", "second T2", {memCsN, rspDone}, 2'b00);
    @(negedge clk);
    check(memCsN && rspDone && rspRdata == {6'h2A, 26'h0222222}, "R11", "second done",
          rspRdata, {6'h2A, 26'h0222222});

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule